// File: doc/BRIEF.md
# Line Error Monitoring Counters

This block gathers line quality statistics for the receive side of a 2.048 Mb/s framed PCM link. It watches two event streams that the framer produces. The first stream reports the check of each frame alignment word. That word is present only in every other timeslot-zero frame, and the framer raises a strobe for each check. The second stream reports each CRC-4 submultiframe check. The framing search and the CRC computation happen upstream of this block.

Errored alignment words are not reported as a count. Instead, a single indicator bit inverts once for every sixteen errors. The inversions are spaced at least 128 ms apart, so software can estimate the bit error rate from the time between inversions, up to a ceiling of about 1e-3. CRC failures go into an 8-bit wrapping counter. In maintenance mode, that counter can also be cleared once per second. Both results leave the block as registered status bytes.

A 1 ms tick and a one-second tick drive all the timing. Each tick is a single-cycle strobe supplied by the system.

Top module: `line_err_monitor`

## Requirements
- R1: An alignment error counts only in a cycle where `faw_chk_stb` and `faw_chk_err` are both 1. `faw_chk_err` without the strobe has no effect. When the window is already open, the edge that registers the 16th counted error since the previous group also inverts the indicator, so it is visible one cycle later.
- R2: The indicator never inverts until 128 `tick_ms` pulses have been registered since the previous inversion or since reset.
- R3: A group of 16 errors that completes while the window is closed is held pending. The indicator inverts on the clock edge after the edge that registers the 128th tick. Errors that arrive while a group is pending keep counting toward the next group. A further group that completes while one is pending merges into that single pending inversion.
- R4: Each cycle with `crc_chk_stb` and `crc_chk_fail` both 1 adds one to `crc_count_o`. The count wraps from 255 to 0.
- R5: When `maint_clr_en` and `tick_sec` are both 1, the CRC count is cleared to 0, or loads 1 if a CRC failure occurs in the same cycle. When `maint_clr_en` is 0, `tick_sec` has no effect.
- R6: `status1_o` carries the indicator at bit 5, and all its other bits are 0. `crc_count_o` is the CRC count.
- R7: Synchronous reset `rst` clears the error group count, the pending flag, the indicator, the interval timer and the CRC count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| faw_chk_stb | input | 1 | One alignment word was checked this cycle |
| faw_chk_err | input | 1 | The checked alignment word was wrong |
| crc_chk_stb | input | 1 | One CRC-4 submultiframe check this cycle |
| crc_chk_fail | input | 1 | The CRC-4 check failed |
| tick_ms | input | 1 | 1 ms timebase strobe |
| tick_sec | input | 1 | One-second strobe |
| maint_clr_en | input | 1 | Enables the per-second CRC count clear |
| status1_o | output | 8 | Status byte, indicator at bit 5 |
| crc_count_o | output | 8 | CRC error count |

## Verification
On every cycle, the assertions check the following properties:
- No indicator inversion comes fewer than 128 ticks after the previous one.
- The CRC count holds when there is no event, steps by exactly one on a failure, and follows the clear-or-load-one rule on a maintenance clear.
- The unused status bits stay 0.

Some behaviours appear only in the bench scenarios:
- The indicator inverts only after exactly sixteen qualified errors.
- A pending group waits for the window and then fires.
- Errors that arrive while a group is pending carry over into the next group.
- The wrap at 255 works as specified.
- `tick_sec` is ignored when maintenance mode is off.

// File: rtl/lem_pkg.sv
package lem_pkg;
  localparam int STAT_BYTE_W   = 8;
  localparam int IND_BIT_POS   = 5;
endpackage

// File: rtl/faw_err_toggle.sv
module faw_err_toggle #(
  parameter int GROUP_SIZE = 16,
  parameter int HOLDOFF_MS = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic err_evt,
  input  logic tick_ms,
  output logic ind_o
);
  localparam int GW = (GROUP_SIZE > 1) ? $clog2(GROUP_SIZE) : 1;
  localparam int TW = $clog2(HOLDOFF_MS + 1);
  localparam logic [GW-1:0] G_LAST = GW'(GROUP_SIZE - 1);
  localparam logic [TW-1:0] T_FULL = TW'(HOLDOFF_MS);

  logic [GW-1:0] grp_q;
  logic [TW-1:0] tmr_q;
  logic          pend_q;
  logic          ind_q;
  logic          grp_done;
  logic          win_open;
  logic          fire;

  assign grp_done = err_evt && (grp_q == G_LAST);
  assign win_open = (tmr_q == T_FULL);
  assign fire     = win_open && (pend_q || grp_done);

  // error group counter, independent of the window
  always_ff @(posedge clk) begin
    if (rst)            grp_q <= '0;
    else if (grp_done)  grp_q <= '0;
    else if (err_evt)   grp_q <= grp_q + 1'b1;
  end

  // interval timer restarts at each inversion and saturates at the window length
  always_ff @(posedge clk) begin
    if (rst)                          tmr_q <= '0;
    else if (fire)                    tmr_q <= '0;
    else if (tick_ms && !win_open)    tmr_q <= tmr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)           pend_q <= 1'b0;
    else if (fire)     pend_q <= 1'b0;
    else if (grp_done) pend_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)       ind_q <= 1'b0;
    else if (fire) ind_q <= ~ind_q;
  end

  assign ind_o = ind_q;
endmodule

// File: rtl/crc_err_counter.sv
module crc_err_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fail_evt,
  input  logic             clr_evt,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (clr_evt)  cnt_q <= fail_evt ? CNT_W'(1) : '0;
    else if (fail_evt) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/line_err_monitor.sv
module line_err_monitor #(
  parameter int GROUP_SIZE = 16,
  parameter int HOLDOFF_MS = 128,
  parameter int CRC_CNT_W  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       faw_chk_stb,
  input  logic       faw_chk_err,
  input  logic       crc_chk_stb,
  input  logic       crc_chk_fail,
  input  logic       tick_ms,
  input  logic       tick_sec,
  input  logic       maint_clr_en,
  output logic [7:0] status1_o,
  output logic [7:0] crc_count_o
);
  import lem_pkg::*;

  logic                 ind;
  logic [CRC_CNT_W-1:0] crc_cnt;

  faw_err_toggle #(
    .GROUP_SIZE (GROUP_SIZE),
    .HOLDOFF_MS (HOLDOFF_MS)
  ) u_faw (
    .clk     (clk),
    .rst     (rst),
    .err_evt (faw_chk_stb & faw_chk_err),
    .tick_ms (tick_ms),
    .ind_o   (ind)
  );

  crc_err_counter #(
    .CNT_W (CRC_CNT_W)
  ) u_crc (
    .clk      (clk),
    .rst      (rst),
    .fail_evt (crc_chk_stb & crc_chk_fail),
    .clr_evt  (maint_clr_en & tick_sec),
    .cnt_o    (crc_cnt)
  );

  always_comb begin
    status1_o = '0;
    status1_o[IND_BIT_POS] = ind;
  end

  generate
    if (CRC_CNT_W >= STAT_BYTE_W) begin : g_crc_trunc
      assign crc_count_o = crc_cnt[STAT_BYTE_W-1:0];
    end else begin : g_crc_pad
      assign crc_count_o = {{(STAT_BYTE_W-CRC_CNT_W){1'b0}}, crc_cnt};
    end
  endgenerate
endmodule

// File: rtl/line_err_monitor_chk.sv
module line_err_monitor_chk #(
  parameter int HOLDOFF_MS = 128
) (
  input logic       clk,
  input logic       rst,
  input logic       crc_chk_stb,
  input logic       crc_chk_fail,
  input logic       tick_ms,
  input logic       tick_sec,
  input logic       maint_clr_en,
  input logic [7:0] status1_o,
  input logic [7:0] crc_count_o
);
  localparam int CW = $clog2(HOLDOFF_MS + 1);
  logic          ind_q;
  logic          was_rst;
  logic [CW-1:0] since_q;
  logic          ind;
  logic          flip;

  assign ind  = status1_o[5];
  assign flip = (ind != ind_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ind_q   <= 1'b0;
      since_q <= '0;
      was_rst <= 1'b1;
    end else begin
      ind_q   <= ind;
      was_rst <= 1'b0;
      if (flip)
        since_q <= tick_ms ? CW'(1) : '0;
      else if (tick_ms && since_q != CW'(HOLDOFF_MS))
        since_q <= since_q + 1'b1;
    end
  end

  // R2
  p_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    flip |-> (since_q == CW'(HOLDOFF_MS)));

  // R4
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!was_rst && !(crc_chk_stb && crc_chk_fail) && !(tick_sec && maint_clr_en))
      |=> $stable(crc_count_o));

  // R4
  p_step_r4: assert property (@(posedge clk) disable iff (rst)
    (!was_rst && crc_chk_stb && crc_chk_fail && !(tick_sec && maint_clr_en))
      |=> (crc_count_o == 8'($past(crc_count_o) + 8'd1)));

  // R5
  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (tick_sec && maint_clr_en)
      |=> (crc_count_o == {7'd0, $past(crc_chk_stb && crc_chk_fail)}));

  // R6
  p_stat_bits_r6: assert property (@(posedge clk) disable iff (rst)
    ((status1_o & 8'hDF) == 8'h00));
endmodule

bind line_err_monitor line_err_monitor_chk #(.HOLDOFF_MS(HOLDOFF_MS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .crc_chk_stb  (crc_chk_stb),
  .crc_chk_fail (crc_chk_fail),
  .tick_ms      (tick_ms),
  .tick_sec     (tick_sec),
  .maint_clr_en (maint_clr_en),
  .status1_o    (status1_o),
  .crc_count_o  (crc_count_o)
);

// File: tb/sim_line_err_monitor.sv
`timescale 1ns/1ps
module sim_line_err_monitor;
  logic clk = 0;
  logic rst = 1;
  logic faw_chk_stb = 0, faw_chk_err = 0, crc_chk_stb = 0, crc_chk_fail = 0;
  logic tick_ms = 0, tick_sec = 0, maint_clr_en = 0;
  logic [7:0] status1_o, crc_count_o;

  int n_chk = 0, n_err = 0, cyc = 0;
  bit done = 0;
  // behavioural reference model state
  int m_grp = 0, m_tmr = 0, m_pend = 0, m_ind = 0, m_crc = 0;

  always #10 clk = ~clk;

  line_err_monitor u0 (.*);

  always @(posedge clk) begin
    if (rst) begin
      m_grp = 0; m_tmr = 0; m_pend = 0; m_ind = 0; m_crc = 0;
    end else begin
      bit ev, gd, fire;
      ev = faw_chk_stb && faw_chk_err;
      gd = ev && (m_grp == 15);
      if (ev) m_grp = (m_grp + 1) % 16;
      fire = (m_pend || gd) && (m_tmr >= 128);
      if (fire) begin
        m_ind = 1 - m_ind; m_tmr = 0; m_pend = 0;
      end else begin
        if (gd) m_pend = 1;
        if (tick_ms && m_tmr < 128) m_tmr++;
      end
      if (maint_clr_en && tick_sec)
        m_crc = (crc_chk_stb && crc_chk_fail) ? 1 : 0;
      else if (crc_chk_stb && crc_chk_fail)
        m_crc = (m_crc + 1) % 256;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model (R1..R7)
  always @(negedge clk) begin
    cyc++;
    if (!rst && !done) begin
      chk("R6 model status1", status1_o, m_ind * 32);
      chk("R4 model crc", crc_count_o, m_crc);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic faw_errs(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); faw_chk_stb = 1; faw_chk_err = 1;
    end
    @(negedge clk); faw_chk_stb = 0; faw_chk_err = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_ms = 1;
    end
    @(negedge clk); tick_ms = 0;
  endtask

  task automatic crc_fails(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); crc_chk_stb = 1; crc_chk_fail = 1;
    end
    @(negedge clk); crc_chk_stb = 0; crc_chk_fail = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    idle(50000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    idle(5);
    @(negedge clk); rst = 0;
    chk("R7 reset status1", status1_o, 0);
    chk("R7 reset crc", crc_count_o, 0);

    // R1: error flag without strobe is ignored
    @(negedge clk); faw_chk_err = 1; idle(20); faw_chk_err = 0;
    // R3: group completes in a closed window -> pending
    faw_errs(16); idle(3);
    chk("R3 pending holds", status1_o, 0);
    ticks(127); idle(3);
    chk("R2 no inversion before 128 ticks", status1_o, 0);
    ticks(1); idle(3);
    chk("R3 pending fires after window", status1_o, 32);

    // R1: open window, 15 errors none, 16th inverts
    ticks(128); idle(2);
    faw_errs(15); idle(3);
    chk("R1 fifteen errors no inversion", status1_o, 32);
    faw_errs(1); idle(2);
    chk("R1 sixteenth error inverts", status1_o, 0);

    // R3: errors while pending carry over to next group
    faw_errs(16); faw_errs(10); idle(2);
    chk("R3 pending with extra errors", status1_o, 0);
    ticks(128); idle(3);
    chk("R3 pending fired", status1_o, 32);
    ticks(128); idle(2);
    faw_errs(5); idle(3);
    chk("R3 carried count not yet full", status1_o, 32);
    faw_errs(1); idle(3);
    chk("R3 carried errors complete group", status1_o, 0);

    // R4 / R5 CRC counter
    crc_fails(255); idle(1);
    chk("R4 count 255", crc_count_o, 255);
    @(negedge clk); tick_sec = 1; @(negedge clk); tick_sec = 0; idle(1);
    chk("R5 tick_sec ignored without maint", crc_count_o, 255);
    crc_fails(1); idle(1);
    chk("R4 wrap to zero", crc_count_o, 0);
    crc_fails(3); idle(1);
    chk("R4 three failures", crc_count_o, 3);
    @(negedge clk); maint_clr_en = 1; tick_sec = 1;
    @(negedge clk); tick_sec = 0; idle(1);
    chk("R5 maint clear", crc_count_o, 0);
    crc_fails(2);
    @(negedge clk); tick_sec = 1; crc_chk_stb = 1; crc_chk_fail = 1;
    @(negedge clk); tick_sec = 0; crc_chk_stb = 0; crc_chk_fail = 0; idle(1);
    chk("R5 clear with coincident failure loads 1", crc_count_o, 1);
    maint_clr_en = 0;

    // R7 mid-run reset
    crc_fails(4); faw_errs(16); ticks(128); idle(3);
    chk("R7 pre-reset status1", status1_o, 32);
    @(negedge clk); rst = 1; idle(2); @(negedge clk); rst = 0;
    chk("R7 mid-run reset status1", status1_o, 0);
    chk("R7 mid-run reset crc", crc_count_o, 0);
    faw_errs(16); ticks(127); idle(3);
    chk("R7 timer cleared by reset", status1_o, 0);
    idle(3);
    finish_run();
  end
endmodule